// File: doc/BRIEF.md
# Bus Fault Register and Detector

This block gathers fault indications from the system bus into a single fault word and tells the interrupt logic when something new has gone wrong. Three lines (memory protection violation, parity error and external address error) are valid only at the moment the address strobe falls. At that moment the type of the cycle in progress selects which bit of the word each line sets. Two more lines, a user-defined fault and a system fault, are level-captured on every clock.

A fault bit stays set until software writes a one to its position through the clear port. Each clock in which a bit goes from 0 to 1 produces a single-cycle level-1 interrupt request. The block also produces two outputs for the bus controller. One is an active-low bus-fault flag, raised for strobe-qualified bus faults and for timeouts. The other is a strobe-inhibit level that memory strobe generation must honour. The timeout counter sits outside the block and delivers a one-cycle pulse.

Top module: `bus_fault_unit`

## Requirements
- R1: While `rst_n` is low, `fault_word` is all zeros, `irq_lvl1` is 0 and `bus_fault_n` is 1.
- R2: If `as_fall` is 1 and `prot_err_n` is 0, the next clock sets bit 0 when `cyc_kind` is memory (2'd0) or I/O (2'd1), and sets bit 1 when `cyc_kind` is DMA (2'd2).
- R3: If `as_fall` is 1 and `par_err_n` is 0, the next clock sets bit 2 for memory, bit 3 for I/O and bit 4 for DMA.
- R4: If `as_fall` is 1 and `addr_err_n` is 0, the next clock sets bit 8 for memory, bit 5 for I/O and bit 14 for DMA.
- R5: The three strobe-sampled lines change no bit when `as_fall` is 0, or when `cyc_kind` is idle (2'd3).
- R6: On any clock with `usr_flt_n` low, bit 7 is set. On any clock with `sys_flt_n` low, bits 13 and 15 are both set. Neither needs `as_fall`.
- R7: A set bit holds until a clock with `clr_en` high and a 1 at that position of `clr_bits`. If a bit is cleared and set on the same clock, it ends up set. Bits with no source (6, 9–12) stay 0.
- R8: `irq_lvl1` is 1 for exactly the clocks after which at least one bit of `fault_word` went from 0 to 1. Setting a bit that is already set raises no request.
- R9: `bus_fault_n` is 0 for the clock after a strobe-sampled fault (any of R2–R4 with a non-idle cycle) or after a clock with `bus_tmo` high. Otherwise it is 1. A timeout sets no fault bit.
- R10: `strobe_inh` is 1, combinationally, whenever `prot_err_n` or `addr_err_n` is 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_fall | input | 1 | One-cycle pulse marking the falling address strobe |
| cyc_kind | input | 2 | Cycle in progress: 0 memory, 1 I/O, 2 DMA, 3 idle |
| prot_err_n | input | 1 | Memory protection fault, active low, strobe-sampled |
| par_err_n | input | 1 | Parity error, active low, strobe-sampled |
| addr_err_n | input | 1 | External address error, active low, strobe-sampled |
| usr_flt_n | input | 1 | User-defined fault, active low, level-captured |
| sys_flt_n | input | 1 | System fault, active low, level-captured |
| bus_tmo | input | 1 | Bus timeout pulse from the external counter |
| clr_en | input | 1 | Write strobe for the write-one-to-clear port |
| clr_bits | input | 16 | Bits to clear when `clr_en` is high |
| fault_word | output | 16 | Fault register contents |
| irq_lvl1 | output | 1 | Level-1 interrupt request pulse |
| bus_fault_n | output | 1 | Bus fault flag, active low |
| strobe_inh | output | 1 | Memory strobe inhibit |

## Verification
The hardest case is a clear and a set landing on the same bit in the same clock, while other bits are either being cleared or are already set. Only then is the priority rule tested, together with the decision on whether an interrupt pulse is due. The stimulus drives each such collision on purpose for a strobe-sampled bit and for a level-captured bit. It then runs a long pseudo-random phase. In that phase the clear port, the strobe, the cycle type and all fault lines toggle independently, and a behavioural model is compared against every output on every clock.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int FLT_W = 16;

    typedef enum logic [1:0] {
        CYC_MEM  = 2'd0,
        CYC_IO   = 2'd1,
        CYC_DMA  = 2'd2,
        CYC_IDLE = 2'd3
    } cyc_e;

    // bit positions in the fault word
    localparam int B_PROT_CPU = 0;
    localparam int B_PROT_DMA = 1;
    localparam int B_PAR_MEM  = 2;
    localparam int B_PAR_IO   = 3;
    localparam int B_PAR_DMA  = 4;
    localparam int B_ADR_IO   = 5;
    localparam int B_USER     = 7;
    localparam int B_ADR_MEM  = 8;
    localparam int B_SYS_LO   = 13;
    localparam int B_ADR_DMA  = 14;
    localparam int B_SYS_HI   = 15;

    // strobe-sampled lines: 0 protection, 1 parity, 2 address
    localparam int N_SLINES = 3;

endpackage

// File: rtl/bfu_set_decode.sv
module bfu_set_decode
    import bfu_pkg::*;
#(
    parameter int W = FLT_W
) (
    input  logic         as_fall,
    input  logic [1:0]   cyc_kind,
    input  logic         prot_err_n,
    input  logic         par_err_n,
    input  logic         addr_err_n,
    input  logic         usr_flt_n,
    input  logic         sys_flt_n,
    output logic [W-1:0] set_vec,
    output logic         bus_hit
);

    localparam int POS_MEM [N_SLINES] = '{B_PROT_CPU, B_PAR_MEM, B_ADR_MEM};
    localparam int POS_IO  [N_SLINES] = '{B_PROT_CPU, B_PAR_IO,  B_ADR_IO};
    localparam int POS_DMA [N_SLINES] = '{B_PROT_DMA, B_PAR_DMA, B_ADR_DMA};

    logic [N_SLINES-1:0] line_low;
    logic [W-1:0]        line_set [N_SLINES];
    logic                strobe_ok;
    logic [W-1:0]        level_set;
    logic [W-1:0]        strobe_set;

    assign line_low  = {~addr_err_n, ~par_err_n, ~prot_err_n};
    assign strobe_ok = as_fall && (cyc_kind != CYC_IDLE);

    for (genvar g = 0; g < N_SLINES; g++) begin : g_line
        always_comb begin
            line_set[g] = '0;
            if (strobe_ok && line_low[g]) begin
                case (cyc_kind)
                    CYC_MEM: line_set[g][POS_MEM[g]] = 1'b1;
                    CYC_IO:  line_set[g][POS_IO[g]]  = 1'b1;
                    CYC_DMA: line_set[g][POS_DMA[g]] = 1'b1;
                    default: line_set[g] = '0;
                endcase
            end
        end
    end

    always_comb begin
        strobe_set = '0;
        for (int i = 0; i < N_SLINES; i++) begin
            strobe_set = strobe_set | line_set[i];
        end
    end

    always_comb begin
        level_set = '0;
        level_set[B_USER]   = ~usr_flt_n;
        level_set[B_SYS_LO] = ~sys_flt_n;
        level_set[B_SYS_HI] = ~sys_flt_n;
    end

    assign set_vec = strobe_set | level_set;
    assign bus_hit = strobe_ok && (|line_low);

endmodule

// File: rtl/bfu_fault_store.sv
module bfu_fault_store
    import bfu_pkg::*;
#(
    parameter int W = FLT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flt_q,
    output logic         irq_q
);

    typedef struct packed {
        logic [W-1:0] flt;
        logic         irq;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff    = clr_en ? clr_bits : '0;
        st_d.flt   = (st_q.flt & ~clr_eff) | set_vec;
        st_d.irq   = |(set_vec & ~st_q.flt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flt_q = st_q.flt;
    assign irq_q = st_q.irq;

    AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flt_q) & ~$past(clr_en ? clr_bits : '0) & ~flt_q) == '0)); // R7

    AST_IRQ_MEANS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((flt_q & ~$past(flt_q)) != '0)); // R8

    AST_RISE_MEANS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((flt_q & ~$past(flt_q)) != '0) |-> irq_q); // R8

endmodule

// File: rtl/bfu_bus_flag.sv
module bfu_bus_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_hit,
    input  logic bus_tmo,
    input  logic prot_err_n,
    input  logic addr_err_n,
    output logic bus_fault_n,
    output logic strobe_inh
);

    typedef struct packed {
        logic flag_n;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.flag_n = ~(bus_hit | bus_tmo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_fault_n = st_q.flag_n;
    assign strobe_inh  = ~prot_err_n | ~addr_err_n;

    AST_TMO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tmo |=> !bus_fault_n); // R9

endmodule

// File: rtl/bus_fault_unit.sv
module bus_fault_unit
    import bfu_pkg::*;
#(
    parameter int W = FLT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         as_fall,
    input  logic [1:0]   cyc_kind,
    input  logic         prot_err_n,
    input  logic         par_err_n,
    input  logic         addr_err_n,
    input  logic         usr_flt_n,
    input  logic         sys_flt_n,
    input  logic         bus_tmo,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] fault_word,
    output logic         irq_lvl1,
    output logic         bus_fault_n,
    output logic         strobe_inh
);

    logic [W-1:0] set_vec;
    logic         bus_hit;

    bfu_set_decode #(.W(W)) u_dec (
        .as_fall    (as_fall),
        .cyc_kind   (cyc_kind),
        .prot_err_n (prot_err_n),
        .par_err_n  (par_err_n),
        .addr_err_n (addr_err_n),
        .usr_flt_n  (usr_flt_n),
        .sys_flt_n  (sys_flt_n),
        .set_vec    (set_vec),
        .bus_hit    (bus_hit)
    );

    bfu_fault_store #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_en   (clr_en),
        .clr_bits (clr_bits),
        .flt_q    (fault_word),
        .irq_q    (irq_lvl1)
    );

    bfu_bus_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_hit     (bus_hit),
        .bus_tmo     (bus_tmo),
        .prot_err_n  (prot_err_n),
        .addr_err_n  (addr_err_n),
        .bus_fault_n (bus_fault_n),
        .strobe_inh  (strobe_inh)
    );

    AST_IDLE_NO_STROBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_fall && usr_flt_n && sys_flt_n) |=> ((fault_word & ~$past(fault_word)) == '0)); // R5

    AST_SYS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_flt_n |=> (fault_word[B_SYS_LO] && fault_word[B_SYS_HI])); // R6

    AST_INHIBIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_err_n || !addr_err_n) |-> strobe_inh); // R10

    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err_n && addr_err_n) |-> !strobe_inh); // R10

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_word[6] == 1'b0) && (fault_word[12:9] == 4'd0)); // R7

endmodule

// File: tb/bus_fault_unit_bench.sv
`timescale 1ns/1ps
module bus_fault_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_fall = 1'b0;
    logic [1:0]  cyc_kind = 2'd3;
    logic        prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
    logic        usr_flt_n = 1'b1, sys_flt_n = 1'b1;
    logic        bus_tmo = 1'b0;
    logic        clr_en = 1'b0;
    logic [15:0] clr_bits = '0;
    logic [15:0] fault_word;
    logic        irq_lvl1, bus_fault_n, strobe_inh;

    int    n_vec = 0;
    int    n_bad = 0;
    string req = "R1";

    // behavioural reference
    logic [15:0] m_flt = '0;
    logic        m_irq = 1'b0;
    logic        m_bf  = 1'b1;

    always #5 clk = ~clk;

    bus_fault_unit u_bus_fault_unit (
        .clk(clk), .rst_n(rst_n), .as_fall(as_fall), .cyc_kind(cyc_kind),
        .prot_err_n(prot_err_n), .par_err_n(par_err_n), .addr_err_n(addr_err_n),
        .usr_flt_n(usr_flt_n), .sys_flt_n(sys_flt_n), .bus_tmo(bus_tmo),
        .clr_en(clr_en), .clr_bits(clr_bits), .fault_word(fault_word),
        .irq_lvl1(irq_lvl1), .bus_fault_n(bus_fault_n), .strobe_inh(strobe_inh)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flt = '0; m_irq = 1'b0; m_bf = 1'b1;
        end else begin
            logic [15:0] s;
            logic [15:0] nx;
            logic        strobed;
            s = '0;
            strobed = as_fall && (cyc_kind != 2'd3);
            if (strobed) begin
                if (!prot_err_n) s[(cyc_kind == 2'd2) ? 1 : 0] = 1'b1;
                if (!par_err_n)  s[(cyc_kind == 2'd0) ? 2 : (cyc_kind == 2'd1) ? 3 : 4] = 1'b1;
                if (!addr_err_n) s[(cyc_kind == 2'd0) ? 8 : (cyc_kind == 2'd1) ? 5 : 14] = 1'b1;
            end
            if (!usr_flt_n) s[7] = 1'b1;
            if (!sys_flt_n) begin s[13] = 1'b1; s[15] = 1'b1; end
            nx    = (m_flt & ~(clr_en ? clr_bits : 16'h0)) | s;
            m_irq = |(nx & ~m_flt);
            m_flt = nx;
            m_bf  = !((strobed && (!prot_err_n || !par_err_n || !addr_err_n)) || bus_tmo);
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_regs();
        chk("fault_word", fault_word, m_flt);
        chk("irq_lvl1", {15'd0, irq_lvl1}, {15'd0, m_irq});
        chk("bus_fault_n", {15'd0, bus_fault_n}, {15'd0, m_bf});
    endtask

    // apply inputs at a falling edge, check the comb output, then compare after the next edge
    task automatic step(input logic af, input logic [1:0] ck, input logic mp, input logic pa,
                        input logic ad, input logic us, input logic sy, input logic to,
                        input logic ce, input logic [15:0] cb);
        as_fall = af; cyc_kind = ck; prot_err_n = mp; par_err_n = pa; addr_err_n = ad;
        usr_flt_n = us; sys_flt_n = sy; bus_tmo = to; clr_en = ce; clr_bits = cb;
        #1;
        chk("strobe_inh R10", {15'd0, strobe_inh}, {15'd0, (!mp || !ad)});
        @(negedge clk);
        cmp_regs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd3, 1, 1, 1, 1, 1, 0, 0, '0);
    endtask

    task automatic clear_all();
        step(0, 2'd3, 1, 1, 1, 1, 1, 0, 1, 16'hFFFF);
        chk("cleared", fault_word, 16'h0000);
    endtask

    logic done = 1'b0;
    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        @(negedge clk); @(negedge clk);
        req = "R1";
        cmp_regs();
        chk("reset word R1", fault_word, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_regs();

        req = "R2";
        for (int c = 0; c < 3; c++) begin
            step(1, c[1:0], 0, 1, 1, 1, 1, 0, 0, '0);
            chk("prot bit R2", fault_word, (c == 2) ? 16'h0002 : 16'h0001);
            clear_all();
        end
        req = "R3";
        for (int c = 0; c < 3; c++) begin
            step(1, c[1:0], 1, 0, 1, 1, 1, 0, 0, '0);
            chk("parity bit R3", fault_word, 16'h0004 << c);
            clear_all();
        end
        req = "R4";
        for (int c = 0; c < 3; c++) begin
            step(1, c[1:0], 1, 1, 0, 1, 1, 0, 0, '0);
            chk("addr bit R4", fault_word, (c == 0) ? 16'h0100 : (c == 1) ? 16'h0020 : 16'h4000);
            clear_all();
        end

        req = "R5";
        step(0, 2'd0, 0, 0, 0, 1, 1, 0, 0, '0);
        chk("no strobe R5", fault_word, 16'h0000);
        step(1, 2'd3, 0, 0, 0, 1, 1, 0, 0, '0);
        chk("idle cycle R5", fault_word, 16'h0000);
        chk("idle flag R5", {15'd0, bus_fault_n}, 16'h0001);

        req = "R6";
        step(0, 2'd3, 1, 1, 1, 0, 1, 0, 0, '0);
        chk("user R6", fault_word, 16'h0080);
        step(0, 2'd3, 1, 1, 1, 1, 0, 0, 0, '0);
        chk("sys R6", fault_word, 16'hA080);

        req = "R7";
        idle(3);
        chk("hold R7", fault_word, 16'hA080);
        step(0, 2'd3, 1, 1, 1, 1, 1, 0, 1, 16'h2000);
        chk("partial clear R7", fault_word, 16'h8080);
        step(0, 2'd3, 1, 1, 1, 0, 1, 0, 1, 16'h0080);
        chk("set beats clear R7", fault_word, 16'h8080);
        req = "R8";
        chk("no irq on reset bit R8", {15'd0, irq_lvl1}, 16'h0000);
        step(1, 2'd1, 0, 1, 1, 1, 1, 0, 1, 16'h0001);
        chk("irq new bit R8", {15'd0, irq_lvl1}, 16'h0001);
        step(1, 2'd1, 0, 1, 1, 1, 1, 0, 0, '0);
        chk("irq repeat R8", {15'd0, irq_lvl1}, 16'h0000);
        clear_all();

        req = "R9";
        step(0, 2'd3, 1, 1, 1, 1, 1, 1, 0, '0);
        chk("tmo flag R9", {15'd0, bus_fault_n}, 16'h0000);
        chk("tmo no bit R9", fault_word, 16'h0000);
        step(0, 2'd3, 1, 1, 1, 1, 1, 0, 0, '0);
        chk("flag release R9", {15'd0, bus_fault_n}, 16'h0001);
        step(1, 2'd2, 1, 0, 1, 1, 1, 0, 0, '0);
        chk("parity flag R9", {15'd0, bus_fault_n}, 16'h0000);

        req = "R10";
        step(0, 2'd3, 1, 1, 0, 1, 1, 0, 0, '0);
        step(0, 2'd3, 0, 1, 1, 1, 1, 0, 0, '0);
        step(0, 2'd3, 1, 0, 1, 1, 1, 0, 0, '0);
        clear_all();

        req = "R7";
        lf = 32'hACE1_2345;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[0], lf[2:1], lf[3] | lf[4], lf[5] | lf[6], lf[7] | lf[8],
                 lf[9] | lf[10] | lf[11], lf[12] | lf[13] | lf[14], lf[15] & lf[16],
                 lf[17], lf[31:16]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule